// File: doc/BRIEF.md
# Indirect Byte Load Unit

This block executes one-word load instructions that fetch a single byte from data memory through one of two 16-bit pointers and place it in a 32-entry, 8-bit register file. The two pointers live in the register file itself: pointer Y occupies entries 29 (high) and 28 (low), pointer Z occupies entries 31 (high) and 30 (low). Four addressing forms are supported: plain, offset by a 6-bit unsigned displacement, post-increment and pre-decrement. The block decodes the opcode, forms the address, issues one read on a valid/ready memory port, writes the returned byte to the destination entry and, for the stepping forms, writes the new pointer back in the same clock edge.

Two build options change the address arithmetic. With `SMALL_DATA` set, only the low pointer byte takes part: addressing and stepping wrap inside 8 bits and the high byte is never changed. With `WIDE_ADDR` set, each pointer has an 8-bit extension byte, the address is 24 bits wide and every carry or borrow runs into that extension byte. The rest of the core loads the register file and the extension bytes through plain write ports and reads the file through a combinational read port. No status flags exist or are touched.

Top module: `ptr_load_unit`

## Requirements
- R1: Opcode fields: destination index is op[8:4]; op[3]=1 selects pointer Y and op[3]=0 selects Z. `1001 000d dddd b001` is post-increment, `1001 000d dddd b010` is pre-decrement, `10q0 qq0d dddd bqqq` is the offset form with displacement {op[13], op[11:10], op[2:0]}; the plain form `1000 000d dddd b000` is the offset form with displacement 0.
- R2: The plain form reads the byte at the pointer, writes it to the destination and leaves the pointer unchanged.
- R3: Post-increment reads at the current pointer, then the pointer becomes pointer + 1.
- R4: Pre-decrement first forms pointer − 1, reads at that address, and writes it back as the new pointer.
- R5: The offset form reads at pointer + displacement (0 to 63) and leaves the pointer unchanged.
- R6: With `WIDE_ADDR`, the address is {extension, high, low} over 24 bits and increment, decrement and displacement carry or borrow into the extension byte, which is written back on stepping forms.
- R7: With `SMALL_DATA`, the address is the low pointer byte (upper address bits zero), all arithmetic wraps within 8 bits, and the high pointer byte is never modified.
- R8: Counted in clock edges from the accepting edge to the edge that raises `done`, with memory always ready: plain and post-increment take 1, pre-decrement and offset with nonzero displacement take 2, and `instr_sram` adds 1.
- R9: While `mem_valid` is high and `mem_ready` is low, the unit keeps `mem_valid` high and `mem_addr` stable, and completes one edge after `mem_ready` is seen.
- R10: A stepping form whose destination belongs to the pointer it steps raises `illegal` together with `done`; the destination write is dropped and the pointer write-back is kept. An opcode outside R1 is accepted, raises `done` and `illegal` one edge later, and makes no memory access and no write.
- R11: `done` is a one-cycle pulse per instruction, and `instr_ready` is high only while the unit is idle.
- R12: After reset the register file and extension bytes read zero, `instr_ready` is high and `done`, `illegal` and `mem_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid | input | 1 | Instruction offered |
| instr_op | input | 16 | Opcode |
| instr_sram | input | 1 | Target is internal SRAM, adds one cycle |
| instr_ready | output | 1 | Unit idle, instruction accepted this edge if offered |
| rf_we | input | 1 | Register file write enable from the core |
| rf_waddr | input | 5 | Register file write index |
| rf_wdata | input | 8 | Register file write data |
| rf_raddr | input | 5 | Register file read index |
| rf_rdata | output | 8 | Register file read data (combinational) |
| ext_we | input | 1 | Extension byte write enable |
| ext_sel_y | input | 1 | 1 writes Y extension, 0 writes Z extension |
| ext_wdata | input | 8 | Extension byte write data |
| ext_y | output | 8 | Y extension byte |
| ext_z | output | 8 | Z extension byte |
| mem_valid | output | 1 | Read request |
| mem_addr | output | AW | Read address (16, or 24 with `WIDE_ADDR`) |
| mem_ready | input | 1 | Memory accepts and returns data this cycle |
| mem_rdata | input | 8 | Returned byte, valid with `mem_ready` |
| done | output | 1 | Destination and pointer writes have committed |
| illegal | output | 1 | Undefined or unsupported form, valid with `done` |

## Verification
Every result of this unit lands on one clock edge: the memory address appears in the first cycle of the access state, and the destination byte, the stepped pointer and the extension byte all commit on the edge that accepts `mem_ready`, so `done` and the written registers are visible together right after that edge. The bench drives inputs on falling edges and samples on falling edges, counting falling edges after the accepting edge until `done` rises, which gives the 1, 2 or 3 cycle figure of R8 directly; register contents are read back through the read port only after `done`. Stall checks hold `mem_ready` low for several falling edges and compare the address each time, then expect `done` exactly one edge after release. Two instances, one 24-bit and one 8-bit-pointer build, receive the same stimulus so both arithmetic variants are compared on each vector.

// File: rtl/ldu_pkg.sv
package ldu_pkg;

   // Addressing forms after decode; plain is an offset of zero
   typedef enum logic [1:0] {
      AM_OFFS = 2'd0,
      AM_POST = 2'd1,
      AM_PRE  = 2'd2
   } amode_e;

   typedef struct packed {
      logic       ok;      // opcode belongs to this unit
      logic       ptr_y;   // 1: Y pair, 0: Z pair
      amode_e     mode;
      logic [4:0] dest;
      logic [5:0] disp;
      logic       clash;   // stepping form writes into its own pointer
   } ldu_dec_t;

   // Register file positions of the pointer pairs (decoded by neighbours)
   localparam int unsigned Y_LO_IDX = 28;
   localparam int unsigned Y_HI_IDX = 29;
   localparam int unsigned Z_LO_IDX = 30;
   localparam int unsigned Z_HI_IDX = 31;

endpackage

// File: rtl/ldu_decode.sv
module ldu_decode
   import ldu_pkg::*;
(
   input  logic [15:0] op,
   output ldu_dec_t    dec
);

   logic is_offs;
   logic is_step;

   always_comb begin
      is_offs = (op[15:14] == 2'b10) && !op[12] && !op[9];
      is_step = (op[15:9] == 7'b1001000) &&
                ((op[2:0] == 3'b001) || (op[2:0] == 3'b010));

      dec.ok    = is_offs || is_step;
      dec.ptr_y = op[3];
      dec.dest  = op[8:4];
      dec.mode  = is_step ? (op[1] ? AM_PRE : AM_POST) : AM_OFFS;
      dec.disp  = is_offs ? {op[13], op[11:10], op[2:0]} : 6'd0;
      // Y owns 28/29 (index bit1 = 0), Z owns 30/31 (index bit1 = 1)
      dec.clash = is_step && (op[8:5] == {3'b111, ~op[3]});
   end

endmodule

// File: rtl/ldu_addr_gen.sv
module ldu_addr_gen
   import ldu_pkg::*;
#(
   parameter bit          SMALL_DATA = 1'b0,
   parameter bit          WIDE_ADDR  = 1'b0,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned AW         = 16
)(
   input  logic [DATA_W-1:0] lo,
   input  logic [DATA_W-1:0] hi,
   input  logic [DATA_W-1:0] ext,
   input  amode_e            mode,
   input  logic [5:0]        disp,
   output logic [AW-1:0]     eff,
   output logic [DATA_W-1:0] n_lo,
   output logic [DATA_W-1:0] n_hi,
   output logic [DATA_W-1:0] n_ext
);

   generate
      if (SMALL_DATA) begin : g_small
         localparam logic [DATA_W-1:0] ONE8 = DATA_W'(1);
         logic [DATA_W-1:0] dec8;
         logic [DATA_W-1:0] inc8;
         logic [DATA_W-1:0] off8;

         assign dec8  = lo - ONE8;
         assign inc8  = lo + ONE8;
         assign off8  = lo + DATA_W'(disp);
         assign eff   = {{(AW-DATA_W){1'b0}}, (mode == AM_PRE) ? dec8 : off8};
         assign n_lo  = (mode == AM_PRE) ? dec8 : inc8;
         assign n_hi  = hi;
         assign n_ext = ext;
      end else begin : g_full
         localparam logic [AW-1:0] ONE = AW'(1);
         logic [AW-1:0] base;
         logic [AW-1:0] dec_a;
         logic [AW-1:0] inc_a;
         logic [AW-1:0] off_a;
         logic [AW-1:0] nxt;

         if (WIDE_ADDR) begin : g_wide
            assign base  = {ext, hi, lo};
            assign n_ext = nxt[AW-1 -: DATA_W];
         end else begin : g_narrow
            assign base  = {hi, lo};
            assign n_ext = ext;
         end

         assign dec_a = base - ONE;
         assign inc_a = base + ONE;
         assign off_a = base + AW'(disp);
         assign eff   = (mode == AM_PRE) ? dec_a : off_a;
         assign nxt   = (mode == AM_PRE) ? dec_a : inc_a;
         assign n_lo  = nxt[DATA_W-1:0];
         assign n_hi  = nxt[2*DATA_W-1:DATA_W];
      end
   endgenerate

endmodule

// File: rtl/ldu_regfile.sv
module ldu_regfile
   import ldu_pkg::*;
#(
   parameter int unsigned REG_CNT = 32,
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned IDX_W   = 5
)(
   input  logic              clk,
   input  logic              rst_n,
   // core write port
   input  logic              we,
   input  logic [IDX_W-1:0]  waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              xe,
   input  logic              xsel_y,
   input  logic [DATA_W-1:0] xdata,
   // load commit
   input  logic              cd_we,
   input  logic [IDX_W-1:0]  cd_idx,
   input  logic [DATA_W-1:0] cd_data,
   input  logic              cp_we,
   input  logic              cp_y,
   input  logic [DATA_W-1:0] cp_lo,
   input  logic [DATA_W-1:0] cp_hi,
   input  logic [DATA_W-1:0] cp_ext,
   // reads
   input  logic [IDX_W-1:0]  raddr,
   output logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] y_lo,
   output logic [DATA_W-1:0] y_hi,
   output logic [DATA_W-1:0] z_lo,
   output logic [DATA_W-1:0] z_hi,
   output logic [DATA_W-1:0] ext_y,
   output logic [DATA_W-1:0] ext_z
);

   logic [DATA_W-1:0] regs [REG_CNT];
   logic [IDX_W-1:0]  p_lo_idx;
   logic [IDX_W-1:0]  p_hi_idx;

   assign p_lo_idx = cp_y ? IDX_W'(Y_LO_IDX) : IDX_W'(Z_LO_IDX);
   assign p_hi_idx = cp_y ? IDX_W'(Y_HI_IDX) : IDX_W'(Z_HI_IDX);

   // Priority per entry: pointer write-back, then load data, then core
   generate
      for (genvar r = 0; r < REG_CNT; r++) begin : g_ent
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               regs[r] <= '0;
            end else if (cp_we && (p_lo_idx == IDX_W'(r))) begin
               regs[r] <= cp_lo;
            end else if (cp_we && (p_hi_idx == IDX_W'(r))) begin
               regs[r] <= cp_hi;
            end else if (cd_we && (cd_idx == IDX_W'(r))) begin
               regs[r] <= cd_data;
            end else if (we && (waddr == IDX_W'(r))) begin
               regs[r] <= wdata;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ext_y <= '0;
         ext_z <= '0;
      end else begin
         if (cp_we && cp_y)        ext_y <= cp_ext;
         else if (xe && xsel_y)    ext_y <= xdata;
         if (cp_we && !cp_y)       ext_z <= cp_ext;
         else if (xe && !xsel_y)   ext_z <= xdata;
      end
   end

   assign rdata = regs[raddr];
   assign y_lo  = regs[Y_LO_IDX];
   assign y_hi  = regs[Y_HI_IDX];
   assign z_lo  = regs[Z_LO_IDX];
   assign z_hi  = regs[Z_HI_IDX];

endmodule

// File: rtl/ptr_load_unit.sv
module ptr_load_unit
   import ldu_pkg::*;
#(
   parameter bit          SMALL_DATA = 1'b0,
   parameter bit          WIDE_ADDR  = 1'b0,
   parameter int unsigned REG_CNT    = 32,
   parameter int unsigned DATA_W     = 8,
   localparam int unsigned IDX_W     = $clog2(REG_CNT),
   localparam int unsigned PTR_W     = 2 * DATA_W,
   localparam int unsigned AW        = WIDE_ADDR ? PTR_W + DATA_W : PTR_W
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              instr_valid,
   input  logic [15:0]       instr_op,
   input  logic              instr_sram,
   output logic              instr_ready,
   input  logic              rf_we,
   input  logic [IDX_W-1:0]  rf_waddr,
   input  logic [DATA_W-1:0] rf_wdata,
   input  logic [IDX_W-1:0]  rf_raddr,
   output logic [DATA_W-1:0] rf_rdata,
   input  logic              ext_we,
   input  logic              ext_sel_y,
   input  logic [DATA_W-1:0] ext_wdata,
   output logic [DATA_W-1:0] ext_y,
   output logic [DATA_W-1:0] ext_z,
   output logic              mem_valid,
   output logic [AW-1:0]     mem_addr,
   input  logic              mem_ready,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              done,
   output logic              illegal
);

   // Elaboration-time parameter checks
   if (SMALL_DATA && WIDE_ADDR) begin : g_bad_mix
      $error("SMALL_DATA and WIDE_ADDR exclude each other");
   end
   if (REG_CNT != 32) begin : g_bad_regs
      $error("REG_CNT must be 32: pointer pairs sit at 28..31");
   end
   if (DATA_W != 8) begin : g_bad_width
      $error("DATA_W must be 8");
   end

   typedef enum logic [1:0] {
      S_IDLE = 2'd0,
      S_ADDR = 2'd1,
      S_XTRA = 2'd2,
      S_MEM  = 2'd3
   } state_e;

   state_e            state_q;
   ldu_dec_t          dec;
   logic              accept;
   logic              need_addr;
   logic              commit;

   logic [DATA_W-1:0] y_lo, y_hi, z_lo, z_hi;
   logic [DATA_W-1:0] sel_lo, sel_hi, sel_ext;
   logic [AW-1:0]     eff;
   logic [DATA_W-1:0] n_lo, n_hi, n_ext;

   logic [AW-1:0]     addr_q;
   logic [DATA_W-1:0] nlo_q, nhi_q, next_q;
   logic [IDX_W-1:0]  dest_q;
   logic              ptr_y_q;
   logic              step_q;
   logic              clash_q;
   logic              sram_q;
   logic              done_q;
   logic              ill_q;

   ldu_decode u_dec (
      .op  (instr_op),
      .dec (dec)
   );

   assign sel_lo  = dec.ptr_y ? y_lo  : z_lo;
   assign sel_hi  = dec.ptr_y ? y_hi  : z_hi;
   assign sel_ext = dec.ptr_y ? ext_y : ext_z;

   ldu_addr_gen #(
      .SMALL_DATA (SMALL_DATA),
      .WIDE_ADDR  (WIDE_ADDR),
      .DATA_W     (DATA_W),
      .AW         (AW)
   ) u_agen (
      .lo    (sel_lo),
      .hi    (sel_hi),
      .ext   (sel_ext),
      .mode  (dec.mode),
      .disp  (dec.disp),
      .eff   (eff),
      .n_lo  (n_lo),
      .n_hi  (n_hi),
      .n_ext (n_ext)
   );

   assign instr_ready = (state_q == S_IDLE);
   assign accept      = instr_valid && instr_ready;
   assign need_addr   = (dec.mode == AM_PRE) ||
                        ((dec.mode == AM_OFFS) && (dec.disp != 6'd0));
   assign commit      = (state_q == S_MEM) && mem_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         addr_q  <= '0;
         nlo_q   <= '0;
         nhi_q   <= '0;
         next_q  <= '0;
         dest_q  <= '0;
         ptr_y_q <= 1'b0;
         step_q  <= 1'b0;
         clash_q <= 1'b0;
         sram_q  <= 1'b0;
         done_q  <= 1'b0;
         ill_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         ill_q  <= 1'b0;
         unique case (state_q)
            S_IDLE: begin
               if (accept) begin
                  if (!dec.ok) begin
                     done_q <= 1'b1;
                     ill_q  <= 1'b1;
                  end else begin
                     addr_q  <= eff;
                     nlo_q   <= n_lo;
                     nhi_q   <= n_hi;
                     next_q  <= n_ext;
                     dest_q  <= dec.dest;
                     ptr_y_q <= dec.ptr_y;
                     step_q  <= (dec.mode != AM_OFFS);
                     clash_q <= dec.clash;
                     sram_q  <= instr_sram;
                     if (need_addr)       state_q <= S_ADDR;
                     else if (instr_sram) state_q <= S_XTRA;
                     else                 state_q <= S_MEM;
                  end
               end
            end
            S_ADDR:  state_q <= sram_q ? S_XTRA : S_MEM;
            S_XTRA:  state_q <= S_MEM;
            S_MEM: begin
               if (mem_ready) begin
                  state_q <= S_IDLE;
                  done_q  <= 1'b1;
                  ill_q   <= clash_q;
               end
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   ldu_regfile #(
      .REG_CNT (REG_CNT),
      .DATA_W  (DATA_W),
      .IDX_W   (IDX_W)
   ) u_rf (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (rf_we),
      .waddr   (rf_waddr),
      .wdata   (rf_wdata),
      .xe      (ext_we),
      .xsel_y  (ext_sel_y),
      .xdata   (ext_wdata),
      .cd_we   (commit && !clash_q),
      .cd_idx  (dest_q),
      .cd_data (mem_rdata),
      .cp_we   (commit && step_q),
      .cp_y    (ptr_y_q),
      .cp_lo   (nlo_q),
      .cp_hi   (nhi_q),
      .cp_ext  (next_q),
      .raddr   (rf_raddr),
      .rdata   (rf_rdata),
      .y_lo    (y_lo),
      .y_hi    (y_hi),
      .z_lo    (z_lo),
      .z_hi    (z_hi),
      .ext_y   (ext_y),
      .ext_z   (ext_z)
   );

   assign mem_valid = (state_q == S_MEM);
   assign mem_addr  = addr_q;
   assign done      = done_q;
   assign illegal   = ill_q;

endmodule

// File: rtl/ldu_chk.sv
module ldu_chk #(
   parameter int unsigned AW         = 16,
   parameter bit          SMALL_DATA = 1'b0
)(
   input logic          clk,
   input logic          rst_n,
   input logic          instr_valid,
   input logic          instr_ready,
   input logic          mem_valid,
   input logic          mem_ready,
   input logic [AW-1:0] mem_addr,
   input logic          done,
   input logic          illegal
);

   // R9
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)));

   // R11
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !(instr_valid && instr_ready)) |=> !done);

   // R11
   idle_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      instr_ready |-> !mem_valid);

   // R10
   illegal_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> done);

   // R8
   done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past((mem_valid && mem_ready) || (instr_valid && instr_ready)));

   generate
      if (SMALL_DATA) begin : g_small
         // R7
         small_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            mem_valid |-> (mem_addr[AW-1:8] == '0));
      end
   endgenerate

endmodule

bind ptr_load_unit ldu_chk #(
   .AW         (AW),
   .SMALL_DATA (SMALL_DATA)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .instr_valid (instr_valid),
   .instr_ready (instr_ready),
   .mem_valid   (mem_valid),
   .mem_ready   (mem_ready),
   .mem_addr    (mem_addr),
   .done        (done),
   .illegal     (illegal)
);

// File: tb/ptr_load_unit_tb.sv
module ptr_load_unit_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        instr_valid = 1'b0;
   logic [15:0] instr_op = '0;
   logic        instr_sram = 1'b0;
   logic        rf_we = 1'b0;
   logic [4:0]  rf_waddr = '0;
   logic [7:0]  rf_wdata = '0;
   logic [4:0]  rf_raddr = '0;
   logic        ext_we = 1'b0;
   logic        ext_sel_y = 1'b0;
   logic [7:0]  ext_wdata = '0;
   logic        mem_ready = 1'b1;

   logic        rdy_w, rdy_s, mv_w, mv_s, done_w, done_s, ill_w, ill_s;
   logic [7:0]  rd_w, rd_s, exy_w, exz_w, exy_s, exz_s, md_w, md_s;
   logic [23:0] ma_w;
   logic [15:0] ma_s;

   int n_chk = 0;
   int n_err = 0;
   int cyc = 0;

   always #10 clk = ~clk;   // 50 MHz

   function automatic logic [7:0] mdata(input logic [23:0] a);
      return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h3C;
   endfunction

   assign md_w = mdata(ma_w);
   assign md_s = mdata({8'h00, ma_s});

   ptr_load_unit #(.SMALL_DATA(1'b0), .WIDE_ADDR(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_op(instr_op),
      .instr_sram(instr_sram), .instr_ready(rdy_w), .rf_we(rf_we),
      .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .rf_raddr(rf_raddr),
      .rf_rdata(rd_w), .ext_we(ext_we), .ext_sel_y(ext_sel_y),
      .ext_wdata(ext_wdata), .ext_y(exy_w), .ext_z(exz_w), .mem_valid(mv_w),
      .mem_addr(ma_w), .mem_ready(mem_ready), .mem_rdata(md_w),
      .done(done_w), .illegal(ill_w));

   ptr_load_unit #(.SMALL_DATA(1'b1), .WIDE_ADDR(1'b0)) u_small (
      .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_op(instr_op),
      .instr_sram(instr_sram), .instr_ready(rdy_s), .rf_we(rf_we),
      .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .rf_raddr(rf_raddr),
      .rf_rdata(rd_s), .ext_we(ext_we), .ext_sel_y(ext_sel_y),
      .ext_wdata(ext_wdata), .ext_y(exy_s), .ext_z(exz_s), .mem_valid(mv_s),
      .mem_addr(ma_s), .mem_ready(mem_ready), .mem_rdata(md_s),
      .done(done_s), .illegal(ill_s));

   typedef struct packed {
      logic [15:0] op;
      logic        sram;
      logic [7:0]  ext;
      logic [7:0]  hi;
      logic [7:0]  lo;
      logic [23:0] addr;   // expected 24-bit address
      logic [23:0] nptr;   // expected {ext,hi,lo} afterwards
      logic [3:0]  lat;
   } vec_t;

   localparam int NV = 7;
   localparam vec_t VECS [NV] = '{
      '{16'h8058, 1'b0, 8'h01, 8'h12, 8'h34, 24'h011234, 24'h011234, 4'd1}, // plain Y r5
      '{16'h9061, 1'b0, 8'h02, 8'hFF, 8'hFF, 24'h02FFFF, 24'h030000, 4'd1}, // Z+ r6 carry
      '{16'h907A, 1'b1, 8'h05, 8'h00, 8'h00, 24'h04FFFF, 24'h04FFFF, 4'd3}, // -Y r7 borrow, sram
      '{16'hAC87, 1'b0, 8'h00, 8'h10, 8'hF0, 24'h00112F, 24'h0010F0, 4'd2}, // Z+63 r8
      '{16'hA09A, 1'b0, 8'h00, 8'h00, 8'h10, 24'h000032, 24'h000010, 4'd2}, // Y+34 r9
      '{16'h8000, 1'b1, 8'h03, 8'h44, 8'h55, 24'h034455, 24'h034455, 4'd2}, // plain Z r0 sram
      '{16'h91F9, 1'b0, 8'h00, 8'h00, 8'h7F, 24'h00007F, 24'h000080, 4'd1}  // Y+ r31
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic wr_rf(input logic [4:0] a, input logic [7:0] d);
      @(negedge clk);
      rf_we = 1'b1; rf_waddr = a; rf_wdata = d;
      @(negedge clk);
      rf_we = 1'b0;
   endtask

   task automatic wr_ext(input logic sy, input logic [7:0] d);
      @(negedge clk);
      ext_we = 1'b1; ext_sel_y = sy; ext_wdata = d;
      @(negedge clk);
      ext_we = 1'b0;
   endtask

   task automatic rd_rf(input logic [4:0] a, output logic [7:0] vw, output logic [7:0] vs);
      rf_raddr = a;
      #1;
      vw = rd_w;
      vs = rd_s;
   endtask

   // Offers op, returns edges from acceptance to done per instance
   task automatic run(input logic [15:0] op, input logic sram,
                      output int lw, output int ls,
                      output logic [23:0] aw, output logic [15:0] as_,
                      output logic iw, output logic is_, output logic busy0);
      logic gw, gs;
      gw = 1'b0; gs = 1'b0; lw = -1; ls = -1;
      aw = '0; as_ = '0; iw = 1'b0; is_ = 1'b0; busy0 = 1'b0;
      @(negedge clk);
      instr_valid = 1'b1; instr_op = op; instr_sram = sram;
      @(negedge clk);
      instr_valid = 1'b0;
      busy0 = !rdy_w;
      for (int i = 0; i < 40; i++) begin
         if (mv_w && !gw) begin aw = ma_w; gw = 1'b1; end
         if (mv_s && !gs) begin as_ = ma_s; gs = 1'b1; end
         if (done_w && lw < 0) begin lw = i; iw = ill_w; end
         if (done_s && ls < 0) begin ls = i; is_ = ill_s; end
         if (lw >= 0 && ls >= 0) break;
         @(negedge clk);
      end
      if (!gw) aw = 24'hFFFFFF;
      if (!gs) as_ = 16'hFFFF;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         n_err++;
         $display("FAIL watchdog act=%0d exp=done", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      int lw, ls;
      logic [23:0] aw;
      logic [15:0] as_;
      logic iw, is_, b0;
      logic [7:0] vw, vs, vw2, vs2;

      repeat (3) @(negedge clk);
      // R12 reset state
      chk("R12 ready", {rdy_w, rdy_s}, 2'b11);
      chk("R12 outs", {done_w, ill_w, mv_w, done_s, ill_s, mv_s}, 6'b0);
      rd_rf(5'd28, vw, vs);
      chk("R12 rf", {vw, vs, exy_w, exz_w}, 32'h0);
      rst_n = 1'b1;

      // Vector table walk: R1..R8 on both builds
      for (int v = 0; v < NV; v++) begin
         logic        py;
         logic [4:0]  d, il, ih;
         logic [7:0]  elo, ehi;
         logic [15:0] eas;
         logic [5:0]  q;
         py = VECS[v].op[3];
         d  = VECS[v].op[8:4];
         il = py ? 5'd28 : 5'd30;
         ih = py ? 5'd29 : 5'd31;
         wr_rf(d, 8'hEE);
         wr_rf(il, VECS[v].lo);
         wr_rf(ih, VECS[v].hi);
         wr_ext(py, VECS[v].ext);
         // small-build expectations (R7)
         q = {VECS[v].op[13], VECS[v].op[11:10], VECS[v].op[2:0]};
         ehi = VECS[v].hi;
         if (VECS[v].op[15:9] == 7'b1001000) begin
            if (VECS[v].op[1]) begin elo = VECS[v].lo - 8'd1; eas = {8'h00, elo}; end
            else begin eas = {8'h00, VECS[v].lo}; elo = VECS[v].lo + 8'd1; end
         end else begin
            elo = VECS[v].lo;
            eas = {8'h00, VECS[v].lo + {2'b00, q}};
         end
         run(VECS[v].op, VECS[v].sram, lw, ls, aw, as_, iw, is_, b0);
         chk($sformatf("R8 lat v%0d", v), lw, VECS[v].lat);
         chk($sformatf("R8 lat small v%0d", v), ls, VECS[v].lat);
         chk($sformatf("R6 addr v%0d", v), aw, VECS[v].addr);
         chk($sformatf("R7 addr v%0d", v), as_, eas);
         chk($sformatf("R10 no illegal v%0d", v), {iw, is_}, 2'b00);
         chk($sformatf("R11 busy v%0d", v), b0, 1'b1);
         @(negedge clk);
         chk($sformatf("R11 pulse v%0d", v), {done_w, done_s}, 2'b00);
         rd_rf(d, vw, vs);
         chk($sformatf("R2 dest v%0d", v), vw, mdata(VECS[v].addr));
         chk($sformatf("R7 dest v%0d", v), vs, mdata({8'h00, eas}));
         rd_rf(il, vw, vs);
         rd_rf(ih, vw2, vs2);
         chk($sformatf("R3 R4 R5 ptr v%0d", v),
             {py ? exy_w : exz_w, vw2, vw}, VECS[v].nptr);
         chk($sformatf("R7 ptr v%0d", v), {vs2, vs}, {ehi, elo});
      end

      // R9 stall: plain Y r2 with ready withheld for three cycles
      wr_rf(5'd28, 8'h40);
      wr_rf(5'd29, 8'h00);
      wr_ext(1'b1, 8'h00);
      @(negedge clk);
      mem_ready = 1'b0;
      instr_valid = 1'b1; instr_op = 16'h8028; instr_sram = 1'b0;
      @(negedge clk);
      instr_valid = 1'b0;
      for (int k = 0; k < 3; k++) begin
         chk("R9 hold valid", {mv_w, mv_s, done_w}, 3'b110);
         chk("R9 hold addr", {ma_w, ma_s}, {24'h000040, 16'h0040});
         @(negedge clk);
      end
      mem_ready = 1'b1;
      @(negedge clk);
      chk("R9 done after ready", {done_w, done_s}, 2'b11);
      rd_rf(5'd2, vw, vs);
      chk("R9 data", {vw, vs}, {mdata(24'h40), mdata(24'h40)});

      // R10 clash: LD r31,-Z, Z = 0x0100
      wr_rf(5'd30, 8'h00);
      wr_rf(5'd31, 8'h01);
      wr_ext(1'b0, 8'h00);
      run(16'h91F2, 1'b0, lw, ls, aw, as_, iw, is_, b0);
      chk("R10 illegal flagged", {iw, is_}, 2'b11);
      chk("R10 lat", lw, 2);
      @(negedge clk);
      rd_rf(5'd31, vw, vs);
      rd_rf(5'd30, vw2, vs2);
      chk("R10 ptr kept wide", {vw, vw2}, 16'h00FF);
      chk("R10 ptr kept small", {vs, vs2}, 16'h01FF);

      // R10 unsupported opcode: no access, done one edge later
      wr_rf(5'd0, 8'h11);
      run(16'h0000, 1'b0, lw, ls, aw, as_, iw, is_, b0);
      chk("R10 unsupported lat", {lw[3:0], ls[3:0]}, 8'h00);
      chk("R10 unsupported flag", {iw, is_}, 2'b11);
      chk("R10 unsupported no access", {aw, as_}, {24'hFFFFFF, 16'hFFFF});
      @(negedge clk);
      rd_rf(5'd0, vw, vs);
      chk("R10 unsupported no write", {vw, vs}, 16'h1111);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
   end

endmodule